// File: doc/BRIEF.md
# Background debug mode controller

This block sits between the bit-level front end of a single-wire debug link and a small CPU. It receives debug commands that have already been deserialised, presented on a valid/ready handshake with a 4-bit opcode and an address-wide data word. It keeps track of whether the CPU is running its program, sleeping in a low-power STOP or WAIT state, halted in background mode, or executing a single traced instruction. It accepts or refuses each command according to that state. The block drives the CPU's halt, single-step and wake controls. It also runs one address-match breakpoint and drives two levels: one that suspends the watchdog and one that keeps the oscillator running.

Memory and register transfers are not performed here. For those commands the block raises an access request to the datapath and waits for its completion strobe. Every command the block accepts ends with a one-cycle done pulse, and every command it refuses ends with a one-cycle reject pulse. At reset release the level on the debug pin picks the start mode.

The run-state machine has the states RS_RESET, RS_RUN, RS_SLEEP, RS_HALT and RS_STEP, with these transitions:
- RS_RESET goes to RS_HALT on the first clock after reset release if the pin is low, and to RS_RUN if it is high.
- RS_RUN goes to RS_HALT on BACKGROUND or on a breakpoint hit. Otherwise it goes to RS_SLEEP while the low-power input is high.
- RS_SLEEP goes to RS_HALT on BACKGROUND, and back to RS_RUN when the low-power input drops.
- RS_HALT goes to RS_RUN on GO and to RS_STEP on TRACE1, in both cases only when no breakpoint hit is present in that cycle.
- RS_STEP goes to RS_HALT on the step-completion strobe or on a breakpoint hit.

The command machine has the states CS_IDLE, CS_ACCESS, CS_STEP, CS_DONE and CS_REJECT, with these transitions:
- CS_IDLE goes to CS_REJECT for an illegal command, to CS_ACCESS for a transfer, to CS_STEP for a trace that leaves halt, and to CS_DONE for anything else.
- CS_ACCESS waits for the datapath completion strobe, then goes to CS_DONE.
- CS_STEP waits for the step to end, then goes to CS_DONE.
- CS_DONE and CS_REJECT return to CS_IDLE after one cycle.

Top module: `dbgm_ctrl`

## Requirements
- R1: On the first clock after reset release the debug pin is sampled. A low level starts the CPU halted in background mode with debug enabled (stat_o = 4'b0011). A high level starts the CPU running with debug disabled (stat_o = 4'b0000). cpu_halt_o is high and cmd_ready_o is low while reset is held.
- R2: Opcodes GO (1), TRACE1 (2), REG_RD (3) and REG_WR (4) are legal only in background mode. Codes 10 to 15 are never legal. An illegal command gives cmd_reject_o for one cycle, starting the cycle after acceptance, and sets the sticky error bit stat_o[3]. It gives no done pulse and leaves the CPU state unchanged.
- R3: REG_RD, REG_WR, MEM_RD (5) and MEM_WR (6) hold acc_req_o high from the cycle after acceptance until acc_done_i is seen. MEM_RD and MEM_WR are legal in any state. cmd_done_o pulses in the cycle after acc_done_i.
- R4: BACKGROUND (0) halts the CPU into background mode one cycle after acceptance, with done in the same cycle. If the CPU is sleeping (cpu_lp_i high while running), cpu_wake_o is high in the accepting cycle. After cpu_lp_i drops, the CPU counts as running again and a BACKGROUND gives no wake.
- R5: GO releases halt one cycle after acceptance and pulses done in that cycle.
- R6: TRACE1 drops halt and raises cpu_step_o one cycle after acceptance. The first cpu_step_done_i strobe brings back halt and done in the next cycle. Later strobes leave halt set and give no done.
- R7: When debug enable (stat_o[0]) and breakpoint enable (stat_o[2]) are both set and cpu_fetch_i is high with cpu_fetch_addr_i equal to the breakpoint address, a running CPU is halted in the next cycle. A different address, or a cleared enable, causes no halt.
- R8: GO or TRACE1 accepted in the same cycle as a breakpoint hit still pulses done, and the CPU stays halted.
- R9: wdog_susp_o is high exactly while the CPU is halted in background mode. It is low in reset, in run, in sleep and during a traced step.
- R10: osc_keep_o follows the debug-enable bit.
- R11: stat_o shows debug enable in bit 0, in-background in bit 1, breakpoint enable in bit 2 and the error flag in bit 3. STAT_RD (7) pulses done. STAT_WR (8) loads enable from data bit 0 and breakpoint enable from data bit 2, clears the error when data bit 3 is 1, and ignores data bit 1. BP_SET (9) loads the breakpoint address from the data word.
- R12: cmd_ready_o is low from the cycle after acceptance through the done or reject cycle. A valid command presented while ready is low is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_pin_i | input | 1 | Debug pin level, sampled at reset release |
| cmd_valid_i | input | 1 | Command present |
| cmd_ready_o | output | 1 | Controller can take a command |
| cmd_op_i | input | 4 | Command opcode |
| cmd_data_i | input | ADDR_W | Command data or address |
| cmd_done_o | output | 1 | One-cycle completion pulse |
| cmd_reject_o | output | 1 | One-cycle refusal pulse |
| acc_req_o | output | 1 | Memory/register transfer request to datapath |
| acc_done_i | input | 1 | Datapath transfer completion |
| stat_o | output | 4 | Status: enable, in-background, bp enable, error |
| cpu_halt_o | output | 1 | Hold the CPU |
| cpu_step_o | output | 1 | CPU executes one instruction |
| cpu_wake_o | output | 1 | Wake the CPU from STOP or WAIT |
| cpu_lp_i | input | 1 | CPU is in STOP or WAIT |
| cpu_step_done_i | input | 1 | Single instruction completed |
| cpu_fetch_i | input | 1 | Fetch address valid |
| cpu_fetch_addr_i | input | ADDR_W | CPU fetch address |
| wdog_susp_o | output | 1 | Suspend the watchdog |
| osc_keep_o | output | 1 | Keep the oscillator running in STOP |

## Verification
The properties assume that acc_done_i is raised only while acc_req_o is high. They also assume that the CPU reports cpu_lp_i only while it is running, and that a command is held stable for its whole accepting cycle. The stimulus meets these assumptions as follows. Inputs change only at falling clock edges. The completion strobe is given only after the request has been seen. Low power is raised only from the running state. Breakpoint fetches are presented only for a single chosen cycle, so the GO and TRACE1 properties apply their conditions only when no fetch is present.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;

    typedef enum logic [3:0] {
        OP_BACKGROUND = 4'd0,
        OP_GO         = 4'd1,
        OP_TRACE1     = 4'd2,
        OP_REG_RD     = 4'd3,
        OP_REG_WR     = 4'd4,
        OP_MEM_RD     = 4'd5,
        OP_MEM_WR     = 4'd6,
        OP_STAT_RD    = 4'd7,
        OP_STAT_WR    = 4'd8,
        OP_BP_SET     = 4'd9
    } dbg_op_e;

    typedef enum logic [2:0] {
        RS_RESET, RS_RUN, RS_SLEEP, RS_HALT, RS_STEP
    } run_state_e;

    typedef enum logic [2:0] {
        CS_IDLE, CS_ACCESS, CS_STEP, CS_DONE, CS_REJECT
    } cmd_state_e;

    typedef enum logic [1:0] {
        CL_HALTED, CL_ANYTIME, CL_BAD
    } op_class_e;

    localparam int OP_W     = 4;
    localparam int STAT_W   = 4;
    localparam int STAT_EN  = 0;
    localparam int STAT_BG  = 1;
    localparam int STAT_BP  = 2;
    localparam int STAT_ERR = 3;

    function automatic op_class_e op_class(input logic [OP_W-1:0] op);
        op_class_e c;
        case (op)
            OP_GO, OP_TRACE1, OP_REG_RD, OP_REG_WR:   c = CL_HALTED;
            OP_BACKGROUND, OP_MEM_RD, OP_MEM_WR,
            OP_STAT_RD, OP_STAT_WR, OP_BP_SET:        c = CL_ANYTIME;
            default:                                  c = CL_BAD;
        endcase
        return c;
    endfunction

    function automatic logic op_uses_datapath(input logic [OP_W-1:0] op);
        return (op == OP_REG_RD) || (op == OP_REG_WR) ||
               (op == OP_MEM_RD) || (op == OP_MEM_WR);
    endfunction

endpackage

// File: rtl/dbgm_brkpt.sv
module dbgm_brkpt #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_addr_i,
    input  logic              arm_i,
    input  logic              fetch_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    output logic              hit_o
);
    logic [ADDR_W-1:0] bp_addr_q;
    logic [ADDR_W-1:0] bit_eq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bp_addr_q <= '0;
        else if (load_i) bp_addr_q <= load_addr_i;
    end

    for (genvar b = 0; b < ADDR_W; b++) begin : g_cmp
        assign bit_eq[b] = ~(bp_addr_q[b] ^ fetch_addr_i[b]);
    end

    assign hit_o = arm_i && fetch_i && (&bit_eq);
endmodule

// File: rtl/dbgm_run_fsm.sv
module dbgm_run_fsm
    import dbgm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_pin_i,
    input  logic       lp_i,
    input  logic       step_done_i,
    input  logic       bp_hit_i,
    input  logic       bg_req_i,
    input  logic       go_req_i,
    input  logic       trace_req_i,
    output logic       cpu_halt_o,
    output logic       cpu_step_o,
    output logic       cpu_wake_o,
    output logic       in_bg_o,
    output logic       strap_take_o,
    output logic       step_end_o,
    output logic       link_up_o
);
    run_state_e state_q, state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_RESET;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            RS_RESET: state_n = strap_pin_i ? RS_RUN : RS_HALT;
            RS_RUN: begin
                if (bg_req_i || bp_hit_i) state_n = RS_HALT;
                else if (lp_i)            state_n = RS_SLEEP;
            end
            RS_SLEEP: begin
                if (bg_req_i)   state_n = RS_HALT;
                else if (!lp_i) state_n = RS_RUN;
            end
            RS_HALT: begin
                if (go_req_i && !bp_hit_i)         state_n = RS_RUN;
                else if (trace_req_i && !bp_hit_i) state_n = RS_STEP;
            end
            RS_STEP: begin
                if (step_done_i || bp_hit_i) state_n = RS_HALT;
            end
            default: state_n = RS_RESET;
        endcase
    end

    always_comb begin
        cpu_halt_o   = (state_q == RS_RESET) || (state_q == RS_HALT);
        cpu_step_o   = (state_q == RS_STEP);
        cpu_wake_o   = (state_q == RS_SLEEP) && bg_req_i;
        in_bg_o      = (state_q == RS_HALT);
        strap_take_o = (state_q == RS_RESET);
        step_end_o   = (state_q == RS_STEP) && (step_done_i || bp_hit_i);
        link_up_o    = (state_q != RS_RESET);
    end
endmodule

// File: rtl/dbgm_cmd_fsm.sv
module dbgm_cmd_fsm
    import dbgm_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid_i,
    input  logic [OP_W-1:0] op_i,
    input  logic            link_up_i,
    input  logic            halted_i,
    input  logic            bp_hit_i,
    input  logic            acc_done_i,
    input  logic            step_end_i,
    output logic            ready_o,
    output logic            done_o,
    output logic            reject_o,
    output logic            acc_req_o,
    output logic            bg_req_o,
    output logic            go_req_o,
    output logic            trace_req_o,
    output logic            stat_wr_o,
    output logic            bp_set_o,
    output logic            err_set_o
);
    cmd_state_e state_q, state_n;
    op_class_e  cls;
    logic       take, legal;

    assign cls   = op_class(op_i);
    assign take  = valid_i && ready_o;
    assign legal = (cls == CL_ANYTIME) || ((cls == CL_HALTED) && halted_i);

    assign bg_req_o    = take && (op_i == OP_BACKGROUND);
    assign go_req_o    = take && legal && (op_i == OP_GO);
    assign trace_req_o = take && legal && (op_i == OP_TRACE1);
    assign stat_wr_o   = take && (op_i == OP_STAT_WR);
    assign bp_set_o    = take && (op_i == OP_BP_SET);
    assign err_set_o   = take && !legal;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            CS_IDLE: begin
                if (take) begin
                    if (!legal)                      state_n = CS_REJECT;
                    else if (op_uses_datapath(op_i)) state_n = CS_ACCESS;
                    else if (trace_req_o && !bp_hit_i) state_n = CS_STEP;
                    else                             state_n = CS_DONE;
                end
            end
            CS_ACCESS: if (acc_done_i) state_n = CS_DONE;
            CS_STEP:   if (step_end_i) state_n = CS_DONE;
            CS_DONE:   state_n = CS_IDLE;
            CS_REJECT: state_n = CS_IDLE;
            default:   state_n = CS_IDLE;
        endcase
    end

    always_comb begin
        ready_o   = (state_q == CS_IDLE) && link_up_i;
        done_o    = (state_q == CS_DONE);
        reject_o  = (state_q == CS_REJECT);
        acc_req_o = (state_q == CS_ACCESS);
    end
endmodule

// File: rtl/dbgm_ctrl.sv
module dbgm_ctrl
    import dbgm_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_pin_i,
    input  logic              cmd_valid_i,
    output logic              cmd_ready_o,
    input  logic [3:0]        cmd_op_i,
    input  logic [ADDR_W-1:0] cmd_data_i,
    output logic              cmd_done_o,
    output logic              cmd_reject_o,
    output logic              acc_req_o,
    input  logic              acc_done_i,
    output logic [3:0]        stat_o,
    output logic              cpu_halt_o,
    output logic              cpu_step_o,
    output logic              cpu_wake_o,
    input  logic              cpu_lp_i,
    input  logic              cpu_step_done_i,
    input  logic              cpu_fetch_i,
    input  logic [ADDR_W-1:0] cpu_fetch_addr_i,
    output logic              wdog_susp_o,
    output logic              osc_keep_o
);
    logic en_q, bpen_q, err_q;
    logic bp_hit, in_bg, strap_take, step_end, link_up;
    logic bg_req, go_req, trace_req, stat_wr, bp_set, err_set;

    dbgm_brkpt #(.ADDR_W(ADDR_W)) brkpt_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (bp_set),
        .load_addr_i  (cmd_data_i),
        .arm_i        (en_q && bpen_q),
        .fetch_i      (cpu_fetch_i),
        .fetch_addr_i (cpu_fetch_addr_i),
        .hit_o        (bp_hit)
    );

    dbgm_run_fsm run_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .strap_pin_i  (dbg_pin_i),
        .lp_i         (cpu_lp_i),
        .step_done_i  (cpu_step_done_i),
        .bp_hit_i     (bp_hit),
        .bg_req_i     (bg_req),
        .go_req_i     (go_req),
        .trace_req_i  (trace_req),
        .cpu_halt_o   (cpu_halt_o),
        .cpu_step_o   (cpu_step_o),
        .cpu_wake_o   (cpu_wake_o),
        .in_bg_o      (in_bg),
        .strap_take_o (strap_take),
        .step_end_o   (step_end),
        .link_up_o    (link_up)
    );

    dbgm_cmd_fsm cmd_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (cmd_valid_i),
        .op_i        (cmd_op_i),
        .link_up_i   (link_up),
        .halted_i    (in_bg),
        .bp_hit_i    (bp_hit),
        .acc_done_i  (acc_done_i),
        .step_end_i  (step_end),
        .ready_o     (cmd_ready_o),
        .done_o      (cmd_done_o),
        .reject_o    (cmd_reject_o),
        .acc_req_o   (acc_req_o),
        .bg_req_o    (bg_req),
        .go_req_o    (go_req),
        .trace_req_o (trace_req),
        .stat_wr_o   (stat_wr),
        .bp_set_o    (bp_set),
        .err_set_o   (err_set)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            bpen_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (strap_take) en_q <= ~dbg_pin_i;
            if (stat_wr) begin
                en_q   <= cmd_data_i[STAT_EN];
                bpen_q <= cmd_data_i[STAT_BP];
                if (cmd_data_i[STAT_ERR]) err_q <= 1'b0;
            end
            if (err_set) err_q <= 1'b1;
        end
    end

    always_comb begin
        stat_o           = '0;
        stat_o[STAT_EN]  = en_q;
        stat_o[STAT_BG]  = in_bg;
        stat_o[STAT_BP]  = bpen_q;
        stat_o[STAT_ERR] = err_q;
        wdog_susp_o      = in_bg;
        osc_keep_o       = en_q;
    end
endmodule

// File: rtl/dbgm_ctrl_chk.sv
module dbgm_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid_i,
    input logic       cmd_ready_o,
    input logic [3:0] cmd_op_i,
    input logic       clr_bit_i,
    input logic       cmd_done_o,
    input logic       cmd_reject_o,
    input logic       acc_req_o,
    input logic       acc_done_i,
    input logic [3:0] stat_o,
    input logic       cpu_halt_o,
    input logic       cpu_step_o,
    input logic       cpu_wake_o,
    input logic       cpu_fetch_i,
    input logic       wdog_susp_o
);
    logic take;
    assign take = cmd_valid_i && cmd_ready_o;

    a_r2_reject_halted_only: assert property (@(posedge clk) disable iff (!rst_n)
        take && (cmd_op_i >= 4'd1) && (cmd_op_i <= 4'd4) && !stat_o[1]
        |=> cmd_reject_o && stat_o[3] && !cmd_done_o);

    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req_o && !acc_done_i |=> acc_req_o);

    a_r4_bg_halts: assert property (@(posedge clk) disable iff (!rst_n)
        take && (cmd_op_i == 4'd0) |=> cpu_halt_o && wdog_susp_o && cmd_done_o);

    a_r4_wake_on_bg_only: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wake_o |-> take && (cmd_op_i == 4'd0));

    a_r5_go_resumes: assert property (@(posedge clk) disable iff (!rst_n)
        take && (cmd_op_i == 4'd1) && stat_o[1] && !cpu_fetch_i
        |=> !cpu_halt_o && cmd_done_o);

    a_r9_wdog_only_halted: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_susp_o |-> cpu_halt_o && !cpu_step_o);

    a_r11_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        take && (cmd_op_i == 4'd8) && clr_bit_i |=> !stat_o[3]);

    a_r12_done_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done_o || cmd_reject_o) |-> !cmd_ready_o);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done_o |=> !cmd_done_o);
endmodule

bind dbgm_ctrl dbgm_ctrl_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_ready_o  (cmd_ready_o),
    .cmd_op_i     (cmd_op_i),
    .clr_bit_i    (cmd_data_i[3]),
    .cmd_done_o   (cmd_done_o),
    .cmd_reject_o (cmd_reject_o),
    .acc_req_o    (acc_req_o),
    .acc_done_i   (acc_done_i),
    .stat_o       (stat_o),
    .cpu_halt_o   (cpu_halt_o),
    .cpu_step_o   (cpu_step_o),
    .cpu_wake_o   (cpu_wake_o),
    .cpu_fetch_i  (cpu_fetch_i),
    .wdog_susp_o  (wdog_susp_o)
);

// File: tb/dbgm_ctrl_tb_top.sv
module dbgm_ctrl_tb_top;
    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dbg_pin = 1'b0;
    logic cmd_valid = 1'b0;
    logic [3:0] cmd_op = '0;
    logic [AW-1:0] cmd_data = '0;
    logic acc_done = 1'b0, cpu_lp = 1'b0, step_done = 1'b0, fetch = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic cmd_ready, cmd_done, cmd_reject, acc_req, halt, step, wake, wdog, osc;
    logic [3:0] stat;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dbgm_ctrl #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .dbg_pin_i(dbg_pin),
        .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_op_i(cmd_op),
        .cmd_data_i(cmd_data), .cmd_done_o(cmd_done), .cmd_reject_o(cmd_reject),
        .acc_req_o(acc_req), .acc_done_i(acc_done), .stat_o(stat),
        .cpu_halt_o(halt), .cpu_step_o(step), .cpu_wake_o(wake),
        .cpu_lp_i(cpu_lp), .cpu_step_done_i(step_done), .cpu_fetch_i(fetch),
        .cpu_fetch_addr_i(fetch_addr), .wdog_susp_o(wdog), .osc_keep_o(osc)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic issue(input logic [3:0] op, input logic [AW-1:0] d);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
        tick;
        cmd_valid = 1'b0;
    endtask

    task automatic do_reset(input logic pin);
        rst_n = 1'b0; dbg_pin = pin;
        tick; tick;
        chk("R1", "halt in reset", halt, 1);
        chk("R1", "ready in reset", cmd_ready, 0);
        chk("R9", "wdog in reset", wdog, 0);
        rst_n = 1'b1;
        tick;
    endtask

    task automatic access(input string req, input logic [3:0] op);
        issue(op, '0);
        chk(req, "acc_req after accept", acc_req, 1);
        chk("R12", "ready while busy", cmd_ready, 0);
        tick;
        chk(req, "acc_req held", acc_req, 1);
        chk(req, "no early done", cmd_done, 0);
        acc_done = 1'b1;
        tick;
        acc_done = 1'b0;
        chk(req, "done after acc_done", cmd_done, 1);
        chk(req, "acc_req dropped", acc_req, 0);
        tick;
        chk("R12", "ready again", cmd_ready, 1);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: strap low -> background
        do_reset(1'b0);
        chk("R1", "halt after strap low", halt, 1);
        chk("R1", "stat after strap low", stat, 4'b0011);
        chk("R10", "osc with enable", osc, 1);
        chk("R9", "wdog halted", wdog, 1);
        chk("R1", "ready after reset", cmd_ready, 1);

        // R3: register access in halt
        access("R3", 4'd3);

        // R11: status read, bp set, status write
        issue(4'd7, '0);
        chk("R11", "stat read done", cmd_done, 1);
        chk("R11", "stat value", stat, 4'b0011);
        tick;
        issue(4'd9, 16'h1234); tick;
        issue(4'd8, 16'h0007); tick;
        chk("R11", "stat write en+bp, bit1 ignored", stat, 4'b0111);

        // R8: GO with breakpoint hit
        fetch = 1'b1; fetch_addr = 16'h1234;
        issue(4'd1, '0);
        chk("R8", "GO vs bp halt", halt, 1);
        chk("R8", "GO vs bp done", cmd_done, 1);
        tick;
        issue(4'd2, '0);
        chk("R8", "TRACE1 vs bp halt", halt, 1);
        chk("R8", "TRACE1 vs bp done", cmd_done, 1);
        chk("R8", "TRACE1 vs bp step", step, 0);
        fetch = 1'b0;
        tick;

        // R6: trace
        issue(4'd2, '0);
        chk("R6", "trace releases halt", halt, 0);
        chk("R6", "trace step level", step, 1);
        chk("R9", "wdog during step", wdog, 0);
        chk("R6", "no done yet", cmd_done, 0);
        step_done = 1'b1;
        tick;
        step_done = 1'b0;
        chk("R6", "halt after strobe", halt, 1);
        chk("R6", "done after strobe", cmd_done, 1);
        tick;
        step_done = 1'b1;
        tick;
        step_done = 1'b0;
        chk("R6", "later strobe halt", halt, 1);
        chk("R6", "later strobe no done", cmd_done, 0);
        tick;

        // R5: GO
        issue(4'd1, '0);
        chk("R5", "GO halt", halt, 0);
        chk("R5", "GO done", cmd_done, 1);
        chk("R9", "wdog running", wdog, 0);
        chk("R11", "stat bg cleared", stat, 4'b0101);
        tick;

        // R2: sweep of illegal codes while running
        for (int op = 1; op < 16; op++) begin
            if (op <= 4 || op >= 10) begin
                issue(op[3:0], '0);
                chk("R2", $sformatf("reject op %0d", op), cmd_reject, 1);
                chk("R2", $sformatf("no done op %0d", op), cmd_done, 0);
                chk("R2", $sformatf("err op %0d", op), stat[3], 1);
                chk("R2", $sformatf("halt kept op %0d", op), halt, 0);
                tick;
                issue(4'd8, 16'h0005); tick;
                chk("R11", "err kept without clear bit", stat[3], 1);
                issue(4'd8, 16'h000D); tick;
                chk("R11", "err cleared", stat, 4'b0101);
            end
        end

        // R3: memory access while running
        access("R3", 4'd6);

        // R12: command held off while busy
        issue(4'd5, '0);
        cmd_valid = 1'b1; cmd_op = 4'd0;
        tick;
        chk("R12", "busy: bg not taken", halt, 0);
        chk("R12", "busy: ready low", cmd_ready, 0);
        cmd_valid = 1'b0;
        acc_done = 1'b1; tick; acc_done = 1'b0;
        chk("R3", "mem read done", cmd_done, 1);
        tick;
        chk("R12", "held command dropped", halt, 0);

        // R7: breakpoint
        fetch = 1'b1; fetch_addr = 16'h1233;
        tick;
        chk("R7", "no hit other addr", halt, 0);
        fetch_addr = 16'h1234;
        tick;
        fetch = 1'b0;
        chk("R7", "hit halts", halt, 1);
        chk("R9", "wdog on bp halt", wdog, 1);

        // R10/R7: disable
        issue(4'd8, 16'h0000); tick;
        chk("R10", "osc off", osc, 0);
        chk("R11", "stat disabled", stat, 4'b0010);
        issue(4'd1, '0); tick;
        fetch = 1'b1; fetch_addr = 16'h1234;
        tick;
        fetch = 1'b0;
        chk("R7", "disabled bp no halt", halt, 0);

        // R4: sleep enter/leave, then wake
        cpu_lp = 1'b1; tick;
        cpu_lp = 1'b0; tick;
        cmd_valid = 1'b1; cmd_op = 4'd0; #1;
        chk("R4", "no wake from run", wake, 0);
        tick; cmd_valid = 1'b0;
        chk("R4", "bg from run halts", halt, 1);
        chk("R4", "bg done", cmd_done, 1);
        tick;
        issue(4'd1, '0); tick;
        cpu_lp = 1'b1; tick;
        chk("R4", "sleep not halted", halt, 0);
        cmd_valid = 1'b1; cmd_op = 4'd0; #1;
        chk("R4", "wake from sleep", wake, 1);
        tick; cmd_valid = 1'b0; cpu_lp = 1'b0;
        chk("R4", "halt after wake", halt, 1);
        chk("R9", "wdog after wake", wdog, 1);

        // R1: strap high
        do_reset(1'b1);
        chk("R1", "run after strap high", halt, 0);
        chk("R1", "stat strap high", stat, 4'b0000);
        chk("R10", "osc off strap high", osc, 0);
        issue(4'd0, '0);
        chk("R4", "bg halts after run start", halt, 1);
        tick;

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule